// File: doc/BRIEF.md
# Windowed Phase-Detector DPLL Core

This block is the core of a digital phase-locked loop. A numerically controlled oscillator (NCO) is a phase accumulator. Its most significant bit is the recovered clock. A signed phase counter sits between that clock and a stream of reference strobes. It counts up on each NCO rising edge and down on each reference strobe. The counter's value steers the NCO in two ways. Each cycle, a proportional term is added to the frequency word. On each NCO rising edge, an integral term is folded into a residual register.

When the counter would leave its signed window, the block raises a loop error. It then re-initialises the counter according to a two-bit policy field. One policy removes the window instead: the counter clamps at its limit and no error is raised. After an error the residual is normally reloaded from its programmed value. In fast-acquisition mode the residual is kept, so the loop resumes at the frequency it had already learned. Errors set a sticky status flag, which a one-cycle clear pulse resets. An enable bit decides whether the flag also drives an interrupt request. Software can watch the live residual and phase count to judge lock.

Top module: `dpll_window_ctrl`

## Requirements
- R1: With no error and no loop reset, the phase count (`pd_phase`, two's complement) rises by 1 in a cycle with an NCO rising edge and no strobe. It falls by 1 in a cycle with a strobe and no NCO edge. It is unchanged when both or neither occur.
- R2: An error occurs when the count would pass +127 or fall below -128. It sets `err_status` on the next edge, whatever the value of `err_int_en`.
- R3: With `init_mode` = 2'b00, an error loads `init_phase` (signed) into the count.
- R4: With `init_mode` = 2'b01, an error loads the opposite limit: -128 after passing +127, and +127 after passing below -128.
- R5: With `init_mode` = 2'b11, an error loads 0, the window centre.
- R6: With `init_mode` = 2'b10, the count clamps at +127 or -128, and no error is raised: neither the status nor the interrupt changes.
- R7: `err_irq` is high exactly when `err_status` is high and `err_int_en` was high at the same edge.
- R8: An `err_clr` pulse clears `err_status`, except when an error occurs in the same cycle; then the status stays set.
- R9: Each cycle the 24-bit accumulator adds the residual plus the sign-extended count shifted left by `gain` (0..7). `nco_clk` is the accumulator MSB. On each NCO rising edge the residual adds the sign-extended count.
- R10: After an error, the residual reloads `resid_prog` when `fast_acq` = 0. When `fast_acq` = 1 the residual keeps its value.
- R11: `rst`, or a `dpll_rst` pulse, clears the accumulator and the count, reloads the residual from `resid_prog`, and suppresses any error in that cycle. `rst` also clears the status and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_evt | input | 1 | Reference timing strobe, one cycle per event |
| init_mode | input | 2 | Error re-initialisation policy |
| fast_acq | input | 1 | Keep the residual across errors |
| err_int_en | input | 1 | Let errors drive the interrupt |
| gain | input | 3 | Proportional shift amount |
| init_phase | input | 8 | Programmed initial count (signed) |
| resid_prog | input | 24 | Programmed residual frequency word |
| dpll_rst | input | 1 | Loop soft reset pulse |
| err_clr | input | 1 | Status clear pulse |
| nco_clk | output | 1 | Recovered clock (accumulator MSB) |
| pd_phase | output | 8 | Current phase count (signed) |
| resid_cur | output | 24 | Current residual |
| err_status | output | 1 | Sticky loop-error flag |
| err_irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a window crossing that lands exactly in a cycle where the status is being cleared. The same applies to a crossing seen under each of the four policies in both directions. The stimulus sets the residual near half the accumulator range, so the NCO produces an edge about every second cycle. It withholds strobes, which drives overflows. It also drives a strobe every cycle with a slow NCO, which forces underflows. During one overflow run the clear pulse is held high continuously, so every crossing coincides with a clear. A behavioural model follows every cycle, so each crossing is checked wherever it falls.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic [1:0] {
    PI_LOAD   = 2'b00,
    PI_OPPOSE = 2'b01,
    PI_FREE   = 2'b10,
    PI_CENTER = 2'b11
  } pinit_e;
endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
  import dpll_pkg::*;
#(
  parameter int PD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dpll_rst,
  input  logic            up,
  input  logic            dn,
  input  pinit_e          mode,
  input  logic [PD_W-1:0] init_phase,
  output logic [PD_W-1:0] pd,
  output logic            err_evt
);
  localparam logic signed [PD_W:0] MAXV = $signed({2'b00, {(PD_W-1){1'b1}}});
  localparam logic signed [PD_W:0] MINV = $signed({2'b11, {(PD_W-1){1'b0}}});

  logic signed [PD_W:0] sum;
  logic                 hi, lo;
  logic [PD_W-1:0]      nxt;

  assign sum = $signed({pd[PD_W-1], pd})
             + $signed({{PD_W{1'b0}}, (up & ~dn)})
             - $signed({{PD_W{1'b0}}, (dn & ~up)});
  assign hi = (sum > MAXV);
  assign lo = (sum < MINV);

  always_comb begin
    nxt     = sum[PD_W-1:0];
    err_evt = 1'b0;
    if (hi || lo) begin
      case (mode)
        PI_FREE:   nxt = hi ? MAXV[PD_W-1:0] : MINV[PD_W-1:0];
        PI_LOAD:   begin nxt = init_phase;  err_evt = 1'b1; end
        PI_OPPOSE: begin nxt = hi ? MINV[PD_W-1:0] : MAXV[PD_W-1:0]; err_evt = 1'b1; end
        default:   begin nxt = '0;          err_evt = 1'b1; end
      endcase
    end
    if (dpll_rst) begin
      nxt     = '0;
      err_evt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pd <= '0;
    else     pd <= nxt;
  end

  // R1
  count_up_chk: assert property (@(posedge clk) disable iff (rst)
    (up && !dn && !dpll_rst && pd != MAXV[PD_W-1:0]) |=> (pd == PD_W'($past(pd) + 1'b1)));
  // R4
  oppose_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (hi && mode == PI_OPPOSE && !dpll_rst) |=> (pd == MINV[PD_W-1:0]));
  // R6
  free_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (hi && mode == PI_FREE && !dpll_rst) |=> (pd == MAXV[PD_W-1:0]));
endmodule

// File: rtl/dpll_nco.sv
module dpll_nco #(
  parameter int NCO_W  = 24,
  parameter int PD_W   = 8,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dpll_rst,
  input  logic              err_evt,
  input  logic              fast_acq,
  input  logic [PD_W-1:0]   pd,
  input  logic [GAIN_W-1:0] gain,
  input  logic [NCO_W-1:0]  resid_prog,
  output logic              nco_clk,
  output logic              rise,
  output logic [NCO_W-1:0]  resid
);
  localparam int EXT_W = NCO_W - PD_W;

  logic [NCO_W-1:0] acc, pd_ext, prop, inc;
  logic             msb_q, reload;

  assign pd_ext  = {{EXT_W{pd[PD_W-1]}}, pd};
  assign prop    = pd_ext << gain;
  assign inc     = resid + prop;
  assign rise    = acc[NCO_W-1] & ~msb_q;
  assign nco_clk = acc[NCO_W-1];
  assign reload  = dpll_rst | (err_evt & ~fast_acq);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      msb_q <= 1'b0;
      resid <= resid_prog;
    end else begin
      if (dpll_rst) begin
        acc   <= '0;
        msb_q <= 1'b0;
      end else begin
        acc   <= acc + inc;
        msb_q <= acc[NCO_W-1];
      end
      if (reload)    resid <= resid_prog;
      else if (rise) resid <= resid + pd_ext;
    end
  end

  // R10
  keep_resid_chk: assert property (@(posedge clk) disable iff (rst)
    (err_evt && fast_acq && !dpll_rst && !rise) |=> $stable(resid));
  // R11
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    dpll_rst |=> (!nco_clk && resid == $past(resid_prog)));
endmodule

// File: rtl/dpll_err_latch.sv
module dpll_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic err_evt,
  input  logic err_clr,
  input  logic int_en,
  output logic status,
  output logic irq
);
  logic st_nxt;

  always_comb begin
    st_nxt = status;
    if (err_evt)      st_nxt = 1'b1;
    else if (err_clr) st_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      status <= st_nxt;
      irq    <= st_nxt & int_en;
    end
  end

  // R2
  err_latch_chk: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> status);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> status);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !err_evt) |=> !status);
endmodule

// File: rtl/dpll_window_ctrl.sv
module dpll_window_ctrl
  import dpll_pkg::*;
#(
  parameter int PD_W   = 8,
  parameter int NCO_W  = 24,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_evt,
  input  logic [1:0]        init_mode,
  input  logic              fast_acq,
  input  logic              err_int_en,
  input  logic [GAIN_W-1:0] gain,
  input  logic [PD_W-1:0]   init_phase,
  input  logic [NCO_W-1:0]  resid_prog,
  input  logic              dpll_rst,
  input  logic              err_clr,
  output logic              nco_clk,
  output logic [PD_W-1:0]   pd_phase,
  output logic [NCO_W-1:0]  resid_cur,
  output logic              err_status,
  output logic              err_irq
);
  logic   rise, err_evt;
  pinit_e mode;

  assign mode = pinit_e'(init_mode);

  dpll_phase_det #(.PD_W(PD_W)) u_pd (
    .clk(clk), .rst(rst), .dpll_rst(dpll_rst), .up(rise), .dn(ref_evt),
    .mode(mode), .init_phase(init_phase), .pd(pd_phase), .err_evt(err_evt)
  );

  dpll_nco #(.NCO_W(NCO_W), .PD_W(PD_W), .GAIN_W(GAIN_W)) u_nco (
    .clk(clk), .rst(rst), .dpll_rst(dpll_rst), .err_evt(err_evt),
    .fast_acq(fast_acq), .pd(pd_phase), .gain(gain), .resid_prog(resid_prog),
    .nco_clk(nco_clk), .rise(rise), .resid(resid_cur)
  );

  dpll_err_latch u_err (
    .clk(clk), .rst(rst), .err_evt(err_evt), .err_clr(err_clr),
    .int_en(err_int_en), .status(err_status), .irq(err_irq)
  );
endmodule

// File: tb/dpll_window_ctrl_tb.sv
`timescale 1ns/1ps
module dpll_window_ctrl_tb;
  localparam longint MASK = 64'hFFFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_evt = 1'b0;
  logic [1:0]  init_mode = 2'b00;
  logic        fast_acq = 1'b0;
  logic        err_int_en = 1'b0;
  logic [2:0]  gain = 3'd0;
  logic [7:0]  init_phase = 8'd0;
  logic [23:0] resid_prog = 24'h200000;
  logic        dpll_rst = 1'b0;
  logic        err_clr = 1'b0;
  logic        nco_clk, err_status, err_irq;
  logic [7:0]  pd_phase;
  logic [23:0] resid_cur;

  int     checks = 0, errors = 0;
  bit     done = 1'b0;
  string  cur_req = "R11";

  int     m_pd;
  longint m_acc, m_resid;
  bit     m_msbq, m_st, m_irq;

  always #2 clk = ~clk;

  dpll_window_ctrl u_dut (
    .clk(clk), .rst(rst), .ref_evt(ref_evt), .init_mode(init_mode),
    .fast_acq(fast_acq), .err_int_en(err_int_en), .gain(gain),
    .init_phase(init_phase), .resid_prog(resid_prog), .dpll_rst(dpll_rst),
    .err_clr(err_clr), .nco_clk(nco_clk), .pd_phase(pd_phase),
    .resid_cur(resid_cur), .err_status(err_status), .err_irq(err_irq)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_pd = 0; m_acc = 0; m_msbq = 0; m_resid = longint'(resid_prog);
      m_st = 0; m_irq = 0;
    end else begin
      bit     rise, e;
      int     n;
      longint na, nr;
      rise = (((m_acc >> 23) & 1) == 1) && !m_msbq;
      n = m_pd + (rise ? 1 : 0) - (ref_evt ? 1 : 0);
      e = 0;
      if (n > 127) begin
        if (init_mode == 2'b10) n = 127;
        else begin
          e = 1;
          n = (init_mode == 2'b00) ? int'($signed(init_phase)) :
              (init_mode == 2'b01) ? -128 : 0;
        end
      end else if (n < -128) begin
        if (init_mode == 2'b10) n = -128;
        else begin
          e = 1;
          n = (init_mode == 2'b00) ? int'($signed(init_phase)) :
              (init_mode == 2'b01) ? 127 : 0;
        end
      end
      if (dpll_rst) begin n = 0; e = 0; end
      if (dpll_rst || (e && !fast_acq)) nr = longint'(resid_prog);
      else if (rise) nr = (m_resid + m_pd) & MASK;
      else nr = m_resid;
      na = dpll_rst ? 0 : (m_acc + m_resid + ((longint'(m_pd) <<< gain) & MASK)) & MASK;
      m_msbq = dpll_rst ? 0 : (((m_acc >> 23) & 1) == 1);
      m_acc = na; m_resid = nr; m_pd = n;
      if (e) m_st = 1; else if (err_clr) m_st = 0;
      m_irq = m_st && err_int_en;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk($signed(pd_phase) == m_pd, cur_req, "pd_phase", $signed(pd_phase), m_pd);
    chk(longint'(resid_cur) == m_resid, "R9", "resid_cur", resid_cur, m_resid);
    chk(nco_clk == m_acc[23], "R9", "nco_clk", nco_clk, m_acc[23]);
    chk(err_status == m_st, (cur_req == "R8") ? "R8" : "R2", "err_status", err_status, m_st);
    chk(err_irq == m_irq, "R7", "err_irq", err_irq, m_irq);
  endtask

  task automatic run(int n, int ref_pct, int clr_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      ref_evt  = ($urandom_range(99) < ref_pct);
      err_clr  = ($urandom_range(99) < clr_pct);
      dpll_rst = 1'b0;
    end
  endtask

  task automatic soft_reset();
    @(negedge clk); compare();
    ref_evt = 0; err_clr = 0; dpll_rst = 1'b1;
    @(negedge clk); compare();
    dpll_rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    @(negedge clk);
    chk(pd_phase == 0 && err_status == 0 && err_irq == 0, "R11", "reset pd/status", pd_phase, 0);
    chk(resid_cur == 24'h200000, "R11", "reset resid", resid_cur, 24'h200000);

    cur_req = "R1"; gain = 3'd2; run(300, 50, 0);
    cur_req = "R9"; gain = 3'd5; run(300, 40, 0);

    // R3: load programmed phase, fast acq off, interrupt masked
    cur_req = "R3"; init_mode = 2'b00; init_phase = 8'hEC; fast_acq = 0;
    err_int_en = 0; gain = 3'd1; resid_prog = 24'h7F0000;
    soft_reset(); run(600, 0, 0);
    chk(err_status == 1, "R2", "status after overflow", err_status, 1);
    chk(err_irq == 0, "R7", "masked irq", err_irq, 0);

    // R8: clear held high while overflows keep coming
    cur_req = "R8"; init_mode = 2'b01; run(600, 0, 100);
    @(negedge clk); compare(); ref_evt = 0; err_clr = 1;
    @(negedge clk); compare(); err_clr = 0;
    chk(err_status == 0, "R8", "cleared status", err_status, 0);

    // R4 / R10: opposing edge with fast acquisition, interrupt on
    cur_req = "R4"; fast_acq = 1; err_int_en = 1; run(400, 0, 0);
    cur_req = "R10"; run(300, 5, 0);
    chk(err_irq == 1, "R7", "enabled irq", err_irq, 1);

    // R5: centre, underflow via strobes every cycle
    cur_req = "R5"; init_mode = 2'b11; fast_acq = 0; resid_prog = 24'h010000;
    soft_reset(); run(400, 100, 0);

    // R6: window disabled, both limits
    cur_req = "R6"; init_mode = 2'b10; err_int_en = 1;
    @(negedge clk); compare(); err_clr = 1;
    @(negedge clk); compare(); err_clr = 0;
    run(300, 100, 0);
    resid_prog = 24'h7F0000; soft_reset(); run(400, 0, 0);
    chk(err_status == 0 && err_irq == 0, "R6", "no error when free", err_status, 0);

    // R11: loop soft reset reloads residual
    cur_req = "R11"; resid_prog = 24'h123456; soft_reset();
    chk(resid_cur == 24'h123456, "R11", "reload resid", resid_cur, 24'h123456);
    chk(pd_phase == 0, "R11", "pd cleared", pd_phase, 0);
    cur_req = "R9"; init_mode = 2'b00; run(200, 30, 10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule